// File: doc/BRIEF.md
# Programmable-Level Interrupt Priority Arbiter

This block gathers maskable interrupt requests from 25 sources and presents one of them to the processor. Every source owns an 8-bit control register. It holds a pending flag, a block flag, a macro-service select, a context-switch select and a two-bit priority level. A one-cycle pulse on a source's request input latches its pending flag. Each cycle the arbiter considers only sources that are pending and not blocked. It keeps those on the best programmed level, where 0 is most urgent. Among them it takes the lowest source index.

The winner's index, its level and its service mode (vectored, macro-service or context-switch) leave the block on registered outputs. The processor acknowledges a source by index, and that clears its pending flag. Software reads any control register combinationally. It can write a whole register in one access or change a single bit without touching the others.

Top module: `lvl_irq_arb`

## Requirements
- R1: After reset every control register reads 8'h43 (pending 0, blocked 1, macro 0, context-switch 0, level 3) and irq_valid is 0; an address of 25 or more reads 8'h00.
- R2: The register view is bit7 pending, bit6 blocked, bit5 macro-service, bit4 context-switch, bits1:0 level; bits 3:2 always read 0; a full write (reg_we=1, reg_bit_op=0) loads those fields from reg_wdata, and a write to an address of 25 or more changes nothing.
- R3: A bit write (reg_we=1, reg_bit_op=1) loads reg_bit_val into the bit numbered reg_bit_sel of the addressed register and leaves all its other bits unchanged; selecting bit 3 or 2 changes nothing.
- R4: A high irq_in[i] at a clock edge sets pending flag i at that edge; the arbitration outputs reflect the new flag at the following edge.
- R5: A blocked source still latches its pending flag but is never reported; once it is unblocked and still pending it takes part.
- R6: Among eligible sources the one with the numerically smallest level wins, whatever the indices.
- R7: Among eligible sources on the winning level the lowest index wins; irq_id is always below 25 when irq_valid is 1.
- R8: irq_level gives the winner's level and irq_mode gives 2 when its context-switch flag is set, otherwise 1 when its macro-service flag is set, otherwise 0; code 3 never appears.
- R9: ack_valid with ack_id = i clears pending flag i at that edge; an ack_id of 25 or more has no effect.
- R10: For the pending flag, a hardware request in the same cycle wins over a software clear and over an acknowledge; a software write of the pending bit wins over an acknowledge.
- R11: With no eligible source, irq_valid, irq_id, irq_level and irq_mode are all 0 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| irq_in | input | 25 | One-cycle request pulse per source |
| reg_we | input | 1 | Register write strobe |
| reg_bit_op | input | 1 | 1: single-bit write, 0: full-register write |
| reg_addr | input | 5 | Source register index for read and write |
| reg_wdata | input | 8 | Full-write data |
| reg_bit_sel | input | 3 | Bit number for a single-bit write |
| reg_bit_val | input | 1 | Value for a single-bit write |
| reg_rdata | output | 8 | Combinational read of the addressed register |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_id | input | 5 | Index of the acknowledged source |
| irq_valid | output | 1 | A source is being presented |
| irq_id | output | 5 | Winning source index |
| irq_level | output | 2 | Winning source level |
| irq_mode | output | 2 | 0 vectored, 1 macro-service, 2 context-switch |

## Verification
The bench sets a high-index source on level 0 against a low-index source on level 2. A design that ranked by index first would report the wrong source there. Ties on a shared level are checked too, because a reversed default order would pick the higher index. A masked source is left pending behind an active one, and a design that arbitrated before masking would present it. The bench fires a request pulse in the same cycle as a bit-clear and an acknowledge of that same flag. A design that let the clear win would lose the interrupt. A long stretch of random pulses, writes and acknowledges is compared every cycle against a behavioural model, which exposes off-by-one output timing and stray bit-write side effects.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int LVL_W = 2;
  localparam int NLVL  = 1 << LVL_W;
  localparam int DW    = 8;
  localparam int B_REQ = 7;
  localparam int B_MSK = 6;
  localparam int B_MAC = 5;
  localparam int B_CSE = 4;

  typedef enum logic [1:0] {
    MODE_VECT  = 2'd0,
    MODE_MACRO = 2'd1,
    MODE_CTX   = 2'd2
  } svc_mode_e;

  typedef struct packed {
    logic             req;
    logic             msk;
    logic             mac;
    logic             cse;
    logic [LVL_W-1:0] lvl;
  } src_ctl_t;

  localparam src_ctl_t CTL_RST = '{req: 1'b0, msk: 1'b1, mac: 1'b0, cse: 1'b0, lvl: '1};

  function automatic logic [DW-1:0] ctl_view(src_ctl_t c);
    logic [DW-1:0] r;
    r = '0;
    r[B_REQ] = c.req;
    r[B_MSK] = c.msk;
    r[B_MAC] = c.mac;
    r[B_CSE] = c.cse;
    r[LVL_W-1:0] = c.lvl;
    return r;
  endfunction
endpackage

// File: rtl/lirq_rst_sync.sv
module lirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/lirq_src_reg.sv
module lirq_src_reg
  import lirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_set,
  input  logic          ack_clr,
  input  logic          wr_full,
  input  logic          wr_bit,
  input  logic [DW-1:0] wdata,
  input  logic [2:0]    bit_sel,
  input  logic          bit_val,
  output src_ctl_t      ctl_q
);
  src_ctl_t ctl_d;
  logic     ld_en;
  logic     unused_wbits;

  assign unused_wbits = ^wdata[3:2];
  assign ld_en = hw_set | ack_clr | wr_full | wr_bit;

  // Order of the updates gives the precedence on the pending flag:
  // acknowledge, then software, then the hardware pulse.
  always_comb begin
    ctl_d = ctl_q;
    if (ack_clr) ctl_d.req = 1'b0;
    if (wr_full) begin
      ctl_d.req = wdata[B_REQ];
      ctl_d.msk = wdata[B_MSK];
      ctl_d.mac = wdata[B_MAC];
      ctl_d.cse = wdata[B_CSE];
      ctl_d.lvl = wdata[LVL_W-1:0];
    end else if (wr_bit) begin
      case (bit_sel)
        3'(B_REQ): ctl_d.req    = bit_val;
        3'(B_MSK): ctl_d.msk    = bit_val;
        3'(B_MAC): ctl_d.mac    = bit_val;
        3'(B_CSE): ctl_d.cse    = bit_val;
        3'd1:      ctl_d.lvl[1] = bit_val;
        3'd0:      ctl_d.lvl[0] = bit_val;
        default:   ;
      endcase
    end
    if (hw_set) ctl_d.req = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= CTL_RST;
    else if (ld_en) ctl_q <= ctl_d;
  end
endmodule

// File: rtl/lirq_select.sv
module lirq_select
  import lirq_pkg::*;
#(
  parameter int N_SRC = 25,
  parameter int ID_W  = $clog2(N_SRC)
) (
  input  src_ctl_t         ctl [N_SRC],
  output logic             found,
  output logic [ID_W-1:0]  win_id,
  output logic [LVL_W-1:0] win_lvl,
  output svc_mode_e        win_mode
);
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] at_lvl [NLVL];
  logic [NLVL-1:0]  lvl_hit;
  logic [LVL_W-1:0] best_lvl;
  logic [N_SRC-1:0] cand;
  src_ctl_t         win_ctl;

  for (genvar s = 0; s < N_SRC; s++) begin : g_elig
    assign elig[s] = ctl[s].req & ~ctl[s].msk;
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign at_lvl[l][s] = elig[s] & (ctl[s].lvl == LVL_W'(l));
    end
    assign lvl_hit[l] = |at_lvl[l];
  end

  // Stage one: the most urgent level that has any eligible source.
  always_comb begin
    best_lvl = '0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (lvl_hit[l]) best_lvl = LVL_W'(l);
    end
  end

  assign cand = at_lvl[best_lvl];

  // Stage two: lowest index on that level.
  always_comb begin
    win_id = '0;
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (cand[s]) win_id = ID_W'(s);
    end
  end

  assign found   = |lvl_hit;
  assign win_ctl = ctl[win_id];
  assign win_lvl = best_lvl;

  always_comb begin
    if (win_ctl.cse)      win_mode = MODE_CTX;
    else if (win_ctl.mac) win_mode = MODE_MACRO;
    else                  win_mode = MODE_VECT;
  end
endmodule

// File: rtl/lvl_irq_arb.sv
module lvl_irq_arb
  import lirq_pkg::*;
#(
  parameter int N_SRC = 25,
  parameter int ID_W  = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             reg_we,
  input  logic             reg_bit_op,
  input  logic [ID_W-1:0]  reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic [2:0]       reg_bit_sel,
  input  logic             reg_bit_val,
  output logic [DW-1:0]    reg_rdata,
  input  logic             ack_valid,
  input  logic [ID_W-1:0]  ack_id,
  output logic             irq_valid,
  output logic [ID_W-1:0]  irq_id,
  output logic [LVL_W-1:0] irq_level,
  output logic [1:0]       irq_mode
);
  logic             rst_q;
  src_ctl_t         ctl [N_SRC];
  logic [DW-1:0]    view [N_SRC];
  logic [N_SRC-1:0] addr_hit;
  logic [N_SRC-1:0] req_vec;
  logic [N_SRC-1:0] mask_vec;

  logic             sel_found;
  logic [ID_W-1:0]  sel_id;
  logic [LVL_W-1:0] sel_lvl;
  svc_mode_e        sel_mode;

  logic             valid_d;
  logic [ID_W-1:0]  id_d;
  logic [LVL_W-1:0] lvl_d;
  logic [1:0]       mode_d;

  lirq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_q)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign addr_hit[s] = (reg_addr == ID_W'(s));

    lirq_src_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_q),
      .hw_set  (irq_in[s]),
      .ack_clr (ack_valid && (ack_id == ID_W'(s))),
      .wr_full (reg_we && !reg_bit_op && addr_hit[s]),
      .wr_bit  (reg_we && reg_bit_op && addr_hit[s]),
      .wdata   (reg_wdata),
      .bit_sel (reg_bit_sel),
      .bit_val (reg_bit_val),
      .ctl_q   (ctl[s])
    );

    assign view[s]     = ctl_view(ctl[s]);
    assign req_vec[s]  = ctl[s].req;
    assign mask_vec[s] = ctl[s].msk;
  end

  always_comb begin
    reg_rdata = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (addr_hit[s]) reg_rdata = view[s];
    end
  end

  lirq_select #(.N_SRC(N_SRC), .ID_W(ID_W)) u_sel (
    .ctl      (ctl),
    .found    (sel_found),
    .win_id   (sel_id),
    .win_lvl  (sel_lvl),
    .win_mode (sel_mode)
  );

  always_comb begin
    valid_d = sel_found;
    id_d    = sel_found ? sel_id  : '0;
    lvl_d   = sel_found ? sel_lvl : '0;
    mode_d  = sel_found ? sel_mode : MODE_VECT;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      irq_valid <= 1'b0;
      irq_id    <= '0;
      irq_level <= '0;
      irq_mode  <= '0;
    end else begin
      irq_valid <= valid_d;
      irq_id    <= id_d;
      irq_level <= lvl_d;
      irq_mode  <= mode_d;
    end
  end
endmodule

// File: rtl/lirq_chk.sv
module lirq_chk #(
  parameter int N_SRC = 25,
  parameter int ID_W  = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst_q,
  input logic [N_SRC-1:0] irq_in,
  input logic             reg_we,
  input logic [ID_W-1:0]  reg_addr,
  input logic             ack_valid,
  input logic [ID_W-1:0]  ack_id,
  input logic [N_SRC-1:0] req_vec,
  input logic [N_SRC-1:0] mask_vec,
  input logic             irq_valid,
  input logic [ID_W-1:0]  irq_id,
  input logic [1:0]       irq_level,
  input logic [1:0]       irq_mode
);
  logic [N_SRC-1:0] ack_hot;
  logic [N_SRC-1:0] win_hot;

  assign ack_hot = {{(N_SRC-1){1'b0}}, 1'b1} << ack_id;
  assign win_hot = {{(N_SRC-1){1'b0}}, 1'b1} << irq_id;

  p_set_latches_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (irq_in != '0) |=> ((req_vec & $past(irq_in)) == $past(irq_in)));

  p_winner_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_q)
    irq_valid |-> ((($past(mask_vec) & win_hot) == '0) && (($past(req_vec) & win_hot) != '0)));

  p_id_in_range_r7: assert property (@(posedge clk) disable iff (!rst_q)
    irq_valid |-> (irq_id < ID_W'(N_SRC)));

  p_mode_legal_r8: assert property (@(posedge clk) disable iff (!rst_q)
    irq_mode != 2'd3);

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (ack_valid && ((irq_in & ack_hot) == '0) && !(reg_we && (reg_addr == ack_id)))
      |=> ((req_vec & $past(ack_hot)) == '0));

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !irq_valid |-> ((irq_id == '0) && (irq_level == 2'd0) && (irq_mode == 2'd0)));
endmodule

bind lvl_irq_arb lirq_chk #(.N_SRC(N_SRC), .ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .irq_in    (irq_in),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .ack_valid (ack_valid),
  .ack_id    (ack_id),
  .req_vec   (req_vec),
  .mask_vec  (mask_vec),
  .irq_valid (irq_valid),
  .irq_id    (irq_id),
  .irq_level (irq_level),
  .irq_mode  (irq_mode)
);

// File: tb/sim_lvl_irq_arb.sv
module sim_lvl_irq_arb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 25;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_in = '0;
  logic          reg_we = 1'b0;
  logic          reg_bit_op = 1'b0;
  logic [IW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [2:0]    reg_bit_sel = '0;
  logic          reg_bit_val = 1'b0;
  logic [7:0]    reg_rdata;
  logic          ack_valid = 1'b0;
  logic [IW-1:0] ack_id = '0;
  logic          irq_valid;
  logic [IW-1:0] irq_id;
  logic [1:0]    irq_level;
  logic [1:0]    irq_mode;

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R1 reset values";

  lvl_irq_arb u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_we(reg_we), .reg_bit_op(reg_bit_op), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_bit_sel(reg_bit_sel), .reg_bit_val(reg_bit_val),
    .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_id(ack_id),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_level(irq_level), .irq_mode(irq_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit m_req [N];
  bit m_msk [N];
  bit m_mac [N];
  bit m_cse [N];
  int m_lvl [N];
  int rel;
  int ev, ei, el, em;

  task automatic model_reset();
    for (int s = 0; s < N; s++) begin
      m_req[s] = 0; m_msk[s] = 1; m_mac[s] = 0; m_cse[s] = 0; m_lvl[s] = 3;
    end
    ev = 0; ei = 0; el = 0; em = 0;
  endtask

  function automatic int view(int a);
    if (a >= N) return 0;
    return m_req[a]*128 + m_msk[a]*64 + m_mac[a]*32 + m_cse[a]*16 + m_lvl[a];
  endfunction

  initial begin
    model_reset();
    rel = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
      rel = 0;
    end else if (rel < 2) begin
      rel++;
      ev = 0; ei = 0; el = 0; em = 0;
    end else begin
      ev = 0; ei = 0; el = 0; em = 0;
      for (int l = 0; l < 4; l++) begin
        for (int s = 0; s < N; s++) begin
          if (ev == 0 && m_req[s] && !m_msk[s] && m_lvl[s] == l) begin
            ev = 1; ei = s; el = l;
            em = m_cse[s] ? 2 : (m_mac[s] ? 1 : 0);
          end
        end
      end
      for (int s = 0; s < N; s++) begin
        if (ack_valid && int'(ack_id) == s) m_req[s] = 0;
        if (reg_we && int'(reg_addr) == s) begin
          if (!reg_bit_op) begin
            m_req[s] = reg_wdata[7]; m_msk[s] = reg_wdata[6];
            m_mac[s] = reg_wdata[5]; m_cse[s] = reg_wdata[4];
            m_lvl[s] = int'(reg_wdata[1:0]);
          end else begin
            case (reg_bit_sel)
              3'd7: m_req[s] = reg_bit_val;
              3'd6: m_msk[s] = reg_bit_val;
              3'd5: m_mac[s] = reg_bit_val;
              3'd4: m_cse[s] = reg_bit_val;
              3'd1: m_lvl[s] = (m_lvl[s] % 2) + 2 * int'(reg_bit_val);
              3'd0: m_lvl[s] = (m_lvl[s] / 2) * 2 + int'(reg_bit_val);
              default: ;
            endcase
          end
        end
        if (irq_in[s]) m_req[s] = 1;
      end
    end
  end

  // Comparison away from the active edge
  always @(negedge clk) begin
    n_cmp++;
    if (int'(irq_valid) != ev || int'(irq_id) != ei || int'(irq_level) != el || int'(irq_mode) != em) begin
      n_bad++;
      $display("FAIL %s: outputs got v=%0d id=%0d lvl=%0d mode=%0d exp v=%0d id=%0d lvl=%0d mode=%0d",
               phase, irq_valid, irq_id, irq_level, irq_mode, ev, ei, el, em);
    end
    n_cmp++;
    if (int'(reg_rdata) != view(int'(reg_addr))) begin
      n_bad++;
      $display("FAIL %s: rdata[%0d] got %02h exp %02h", phase, reg_addr, reg_rdata, view(int'(reg_addr)));
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic rd(int a);
    reg_addr = IW'(a);
    tick();
  endtask

  task automatic wr_full(int a, logic [7:0] d);
    reg_we = 1; reg_bit_op = 0; reg_addr = IW'(a); reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic wr_bit(int a, int b, bit v);
    reg_we = 1; reg_bit_op = 1; reg_addr = IW'(a); reg_bit_sel = 3'(b); reg_bit_val = v;
    tick();
    reg_we = 0; reg_bit_op = 0;
  endtask

  task automatic pulse(logic [N-1:0] m);
    irq_in = m;
    tick();
    irq_in = '0;
  endtask

  task automatic ack(int id);
    ack_valid = 1; ack_id = IW'(id);
    tick();
    ack_valid = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang exp completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    phase = "R1 reset values";
    for (int a = 0; a < 32; a++) rd(a);

    phase = "R2 full write";
    wr_full(3, 8'hFF);
    idle(3);
    wr_full(3, 8'h5E);
    idle(2);
    wr_full(3, 8'h43);
    wr_full(30, 8'hFF);
    rd(30);
    rd(3);

    phase = "R3 bit write";
    wr_bit(5, 5, 1);
    wr_bit(5, 3, 1);
    wr_bit(5, 2, 1);
    wr_bit(5, 1, 0);
    wr_bit(5, 6, 0);
    wr_bit(5, 7, 1);
    idle(3);
    wr_bit(5, 7, 0);
    wr_bit(5, 6, 1);
    wr_bit(5, 5, 0);
    wr_bit(5, 1, 1);
    rd(5);

    phase = "R4 request pulse";
    wr_bit(10, 6, 0);
    pulse(N'(1) << 10);
    idle(3);

    phase = "R5 masked source";
    pulse(N'(1) << 12);
    idle(3);
    ack(10);
    idle(3);
    wr_bit(12, 6, 0);
    idle(3);
    ack(12);
    idle(2);

    phase = "R6 level beats index";
    wr_full(20, 8'h00);
    wr_full(2, 8'h02);
    pulse((N'(1) << 2) | (N'(1) << 20));
    idle(3);
    ack(20);
    idle(3);
    ack(2);
    idle(2);

    phase = "R7 tie on level";
    wr_full(7, 8'h01);
    wr_full(15, 8'h01);
    pulse((N'(1) << 7) | (N'(1) << 15));
    idle(3);
    ack(7);
    idle(3);
    ack(15);
    idle(2);

    phase = "R8 service mode";
    wr_full(7, 8'h21);
    pulse(N'(1) << 7);
    idle(3);
    wr_bit(7, 4, 1);
    idle(3);
    wr_bit(7, 5, 0);
    idle(2);

    phase = "R9 acknowledge";
    ack(31);
    idle(2);
    ack(7);
    idle(3);

    phase = "R10 set wins";
    irq_in = N'(1) << 7;
    reg_we = 1; reg_bit_op = 1; reg_addr = 7; reg_bit_sel = 3'd7; reg_bit_val = 0;
    ack_valid = 1; ack_id = 7;
    tick();
    irq_in = '0; reg_we = 0; reg_bit_op = 0; ack_valid = 0;
    idle(3);
    ack_valid = 1; ack_id = 7;
    reg_we = 1; reg_bit_op = 0; reg_addr = 7; reg_wdata = 8'h81;
    tick();
    ack_valid = 0; reg_we = 0;
    idle(3);
    ack(7);
    idle(2);

    phase = "R11 idle outputs";
    for (int s = 0; s < N; s++) wr_full(s, 8'h00);
    idle(4);

    phase = "R6 R7 R10 random mix";
    for (int c = 0; c < 1500; c++) begin
      int r;
      irq_in = N'($urandom & $urandom & $urandom);
      r = int'($urandom % 8);
      if (r == 0) begin
        reg_we = 1; reg_bit_op = 0;
        reg_addr = IW'($urandom); reg_wdata = 8'($urandom);
      end else if (r == 1) begin
        reg_we = 1; reg_bit_op = 1; reg_addr = IW'($urandom);
        reg_bit_sel = 3'($urandom); reg_bit_val = 1'($urandom);
      end else if (r == 2 || r == 3) begin
        ack_valid = 1;
        ack_id = (ev != 0) ? IW'(ei) : IW'($urandom);
      end else begin
        reg_addr = IW'($urandom);
      end
      tick();
      reg_we = 0; reg_bit_op = 0; ack_valid = 0; irq_in = '0;
    end
    idle(3);

    summary();
    $finish;
  end
endmodule